// File: doc/BRIEF.md
# Two-Phase PWM Timebase with Shared Sync

This block is the digital timebase of a switching controller. Each period has two parts. The first is an on-allowed ramp phase, and its length comes from one register. The second is a deadtime phase, and its length comes from a second register. The two lengths are independent. During the ramp phase, a ramp count rises from zero by one per cycle. A digital PWM comparator elsewhere compares this count with its threshold. A clock strobe is high for the whole deadtime phase. That interval is the forced off-time between output pulses, so the deadtime bounds the maximum duty cycle.

The strobe also leaves the block on a sync output. Several timebases can be linked by feeding a shared sync line into each sync input. A timebase cuts its ramp short when it sees a rising edge on that line during its ramp phase. The result is that a linked group runs at the period of its fastest member.

Top module: `pwm_timebase`

## Requirements
- R1: During and right after reset the block is in the deadtime phase: the strobe is 1, the sync output is 1 and the ramp count is 0.
- R2: With enable high, the deadtime phase lasts max(dead_len,1) clock cycles, and the strobe is 1 in each of them.
- R3: The ramp phase lasts max(ramp_len,1) cycles unless a sync cut ends it early. During it the strobe is 0 and the ramp count reads 0, 1, 2, … in successive cycles.
- R4: The ramp count is 0 throughout the deadtime phase, and every ramp phase starts with a count of 0.
- R5: A dead_len of 0 gives a deadtime phase of exactly one cycle.
- R6: The sync output equals the strobe in every cycle.
- R7: A sync_in rising edge is detected when sync_in is 1 at a clock edge and was 0 at the previous edge. If the block is in the ramp phase at that edge, the block is in the deadtime phase in the next cycle, with the count at 0.
- R8: A sync_in rising edge seen while the block is in the deadtime phase has no effect, and a sync_in that stays high does not cut a later ramp.
- R9: While enable is 0, the block stays in the deadtime phase with the count at 0. After enable rises, a full deadtime phase runs before the first ramp.
- R10: A ramp_len of 0 gives a ramp phase of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the timebase when 1, holds the deadtime phase when 0 |
| ramp_len | input | CNT_W | Ramp phase length in cycles (0 treated as 1) |
| dead_len | input | CNT_W | Deadtime phase length in cycles (0 treated as 1) |
| sync_in | input | 1 | Shared sync line, synchronous to clk |
| sync_out | output | 1 | Copy of the deadtime strobe, driven onto the shared line |
| clk_strobe | output | 1 | 1 during the deadtime phase |
| ramp_cnt | output | CNT_W | Ramp count, 0 during the deadtime phase |

## Verification
The timebase is first run free with several ramp and deadtime pairs, including zero in each register. This separates a correct clamp from an off-by-one in the phase lengths. Sync pulses arriving in the ramp phase at a shorter period than the local one stand in for a faster peer, and they show whether the period locks to that peer. Sync edges placed inside the deadtime phase, and a sync line held high, show that only a fresh edge during the ramp acts. Dropping enable in the middle of a ramp checks the hold and the full deadtime that follows on restart.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    typedef enum logic {
        PH_RAMP = 1'b0,
        PH_DEAD = 1'b1
    } phase_e;

    localparam int unsigned DEF_CNT_W = 8;

endpackage

// File: rtl/pwm_sync_edge.sv
module pwm_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = sync_in && !st_q.prev;

    // R8
    held_level_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_in) && sync_in |-> !rise);
endmodule

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl
    import pwm_tb_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] ramp_len,
    input  logic [CNT_W-1:0] dead_len,
    input  logic             cut,
    output logic             strobe,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic [CNT_W-1:0] dead_last, ramp_last;

    function automatic logic [CNT_W-1:0] last_index(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - ONE;
    endfunction

    always_comb begin
        dead_last = last_index(dead_len);
        ramp_last = last_index(ramp_len);
        st_d      = st_q;
        if (!enable) begin
            st_d.phase = PH_DEAD;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_DEAD) begin
            if (st_q.cnt >= dead_last) begin
                st_d.phase = PH_RAMP;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end else begin
            if (cut || st_q.cnt >= ramp_last) begin
                st_d.phase = PH_DEAD;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_DEAD;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = (st_q.phase == PH_DEAD);
    assign count  = strobe ? '0 : st_q.cnt;

    // R9
    hold_dead_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> strobe && count == '0);

    // R7
    sync_cut_ends_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && cut && !strobe |=> strobe);

    // R3
    ramp_steps_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !cut && !strobe |=> strobe || count == $past(count) + ONE);

    // R4
    ramp_starts_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> count == '0);

    // R5
    min_dead_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && dead_len == '0 && $rose(strobe) && $stable(dead_len) |=> !strobe || !enable);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] ramp_len,
    input  logic [CNT_W-1:0] dead_len,
    input  logic             sync_in,
    output logic             sync_out,
    output logic             clk_strobe,
    output logic [CNT_W-1:0] ramp_cnt
);
    logic sync_rise;

    pwm_sync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .rise    (sync_rise)
    );

    pwm_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .ramp_len (ramp_len),
        .dead_len (dead_len),
        .cut      (sync_rise),
        .strobe   (clk_strobe),
        .count    (ramp_cnt)
    );

    assign sync_out = clk_strobe;

    // R6
    sync_mirrors_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out == clk_strobe);
endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
    localparam int W = 8;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         enable = 0;
    logic [W-1:0] ramp_len = 8'd5;
    logic [W-1:0] dead_len = 8'd3;
    logic         sync_in = 0;
    logic         sync_out, clk_strobe;
    logic [W-1:0] ramp_cnt;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    int m_dead = 1;
    int m_cnt = 0;
    int m_prev = 0;

    always #10 clk = ~clk;

    pwm_timebase #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ramp_len(ramp_len), .dead_len(dead_len),
        .sync_in(sync_in), .sync_out(sync_out),
        .clk_strobe(clk_strobe), .ramp_cnt(ramp_cnt)
    );

    // Behavioural reference: one step per clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dead = 1; m_cnt = 0; m_prev = 0;
        end else begin
            int edge_seen;
            int lim;
            edge_seen = (sync_in && !m_prev) ? 1 : 0;
            m_prev = sync_in ? 1 : 0;
            if (!enable) begin
                m_dead = 1; m_cnt = 0;
            end else if (m_dead == 1) begin
                lim = (dead_len == 0) ? 1 : int'(dead_len);
                if (m_cnt + 1 >= lim) begin m_dead = 0; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end else begin
                lim = (ramp_len == 0) ? 1 : int'(ramp_len);
                if (edge_seen == 1 || m_cnt + 1 >= lim) begin m_dead = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic check(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model on every falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(int'(clk_strobe), m_dead, "strobe");
            check(int'(sync_out), m_dead, "sync_out R6");
            check(int'(ramp_cnt), (m_dead == 1) ? 0 : m_cnt, "ramp_cnt");
        end
    endtask

    initial begin
        #3_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int run;
        // R1: reset state
        tag = "R1";
        @(negedge clk);
        check(int'(clk_strobe), 1, "reset strobe");
        check(int'(sync_out), 1, "reset sync_out");
        check(int'(ramp_cnt), 0, "reset count");
        rst_n = 1;
        step(2);

        // R9: disabled, sync toggling has no effect
        tag = "R9";
        for (int i = 0; i < 6; i++) begin sync_in = ~sync_in; step(1); end
        sync_in = 0;

        // R2 R3 R4 R6: free run
        tag = "R2/R3/R4";
        enable = 1;
        step(40);
        ramp_len = 8'd9; dead_len = 8'd1;
        step(30);

        // R5: zero deadtime clamps to one cycle
        tag = "R5";
        ramp_len = 8'd4; dead_len = 8'd0;
        step(12);
        while (clk_strobe !== 1'b1) step(1);
        run = 0;
        while (clk_strobe === 1'b1) begin run++; step(1); end
        check(run, 1, "dead length with zero register");

        // R10: zero ramp clamps to one cycle
        tag = "R10";
        ramp_len = 8'd0; dead_len = 8'd2;
        step(12);
        while (clk_strobe !== 1'b0) step(1);
        run = 0;
        while (clk_strobe === 1'b0) begin run++; step(1); end
        check(run, 1, "ramp length with zero register");

        // R7: faster peer pulses the shared line every 9 cycles
        tag = "R7";
        ramp_len = 8'd20; dead_len = 8'd2;
        for (int p = 0; p < 8; p++) begin
            sync_in = 1; step(2);
            sync_in = 0; step(7);
        end

        // R8: edges only inside deadtime, then a level held high
        tag = "R8";
        ramp_len = 8'd6; dead_len = 8'd4;
        for (int p = 0; p < 30; p++) begin
            sync_in = (m_dead == 1) ? 1'b1 : 1'b0;
            step(1);
        end
        sync_in = 1;
        step(30);
        sync_in = 0;
        step(3);

        // R9: drop enable mid-ramp, restart with a full deadtime
        tag = "R9";
        while (clk_strobe !== 1'b0) step(1);
        step(2);
        enable = 0;
        step(5);
        enable = 1;
        step(25);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule